// File: doc/BRIEF.md
# Shared Serial Configuration Bus Master

This block lets a host program two devices that sit on one serial clock line and one bidirectional data line. One device is a baseband register file. It uses an active-low chip select, an address strobe and a read/write direction line. The other is a frequency synthesizer. It takes a 22-bit frame and stores it when a latch-enable pulse follows the last bit.

The host issues one request at a time. A request names the target, the direction, a 7-bit address and a data word. The block then produces the complete bus waveform: chip select, strobe and direction for the baseband device, or the frame followed by the latch pulse for the synthesizer. On a baseband read the block stops driving the data line after the address. It shifts the returned byte in and hands it back with a one-cycle valid pulse.

The serial clock comes from dividing the system clock. Its half period is a parameter, and elaboration rejects any value that would push the serial clock above 10 MHz. A busy flag covers each transaction and the settling gap after it.

Top module: `cfgbus_master`

## Requirements
- R1: Every word is shifted most-significant bit first. A baseband frame is 7 address bits followed by 8 data bits (req_data[7:0]). A synthesizer frame is 22 bits, req_data[21] first and req_data[0] last.
- R2: Each bit is set up while sclk is low, and the target captures it on the rising edge. Rising edges within a frame are exactly 2*SCLK_HALF system cycles apart. Elaboration rejects a SCLK_HALF that would make the serial clock faster than SCLK_MAX_HZ.
- R3: On a baseband access bb_as is 1 at the 7 address-bit rising edges and 0 at the 8 data-bit rising edges. It changes only while sclk is low.
- R4: bb_rdwr (1 = read, 0 = write) takes the request's direction together with the fall of bb_cs_n. This is SCLK_HALF cycles before the first rising edge. It stays stable while bb_cs_n is low.
- R5: bb_cs_n is low at every rising edge of a baseband frame. It stays high for the whole of a synthesizer frame.
- R6: On a baseband read, sdata_oe is 1 at the address-bit edges and 0 at the data-bit edges. The 8 bits on sdata_i are sampled on rising edges, the first one going to bit 7. rd_data carries them, and rd_valid pulses for one cycle in the cycle that bb_cs_n returns high. Writes and synthesizer frames give no rd_valid.
- R7: After the 22nd synthesizer bit, synth_le goes high for exactly SCLK_HALF cycles. During that time sclk is low, sdata_oe is 0 and bb_cs_n is high.
- R8: Only one target is active at a time: bb_cs_n low and synth_le high never occur together. A request presented while busy is 1 is ignored.
- R9: busy stays high for at least one serial period (2*SCLK_HALF cycles) after bb_cs_n returns high or synth_le returns low.
- R10: While bb_reset_n is 0, a baseband request is ignored: busy and sclk stay low. A synthesizer request is still carried out.
- R11: After reset, sclk, sdata_oe, synth_le, busy and rd_valid are 0, and bb_cs_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset of the master |
| bb_reset_n | input | 1 | Baseband reset level; 0 blocks baseband access |
| req_valid | input | 1 | Request present (taken when busy is 0) |
| req_target | input | 1 | 0 = baseband, 1 = synthesizer |
| req_read | input | 1 | 1 = baseband read (ignored for synthesizer) |
| req_addr | input | ADDR_W | Baseband register address |
| req_data | input | DIN_W | Write byte in low bits, or synthesizer frame |
| busy | output | 1 | Transaction or settling gap in progress |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds read result |
| rd_data | output | BB_DATA_W | Byte returned by a baseband read |
| sclk | output | 1 | Serial clock |
| sdata_o | output | 1 | Serial data driven by the master |
| sdata_oe | output | 1 | Drive enable for the shared data line |
| sdata_i | input | 1 | Sampled level of the shared data line |
| bb_as | output | 1 | Address strobe: 1 for address bits, 0 for data bits |
| bb_rdwr | output | 1 | Baseband direction, 1 = read |
| bb_cs_n | output | 1 | Baseband chip select, active low |
| synth_le | output | 1 | Synthesizer latch enable |

## Verification
The bench mixes seeded random requests with directed ones. The random requests vary the target, the direction, the address, the write word and the byte returned on reads. The directed cases use all-zero and all-one addresses and words, and single-bit synthesizer frames. These patterns separate a correct bit order from a reversed or shifted one, and show whether the strobe boundary falls at the correct bit. Reads with alternating and uniform return bytes show whether sampling happens on the correct edge and whether the line is released at the correct bit. Further cases present requests while busy and baseband requests while bb_reset_n is low. These show whether a second request or a blocked one is wrongly started.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_LATCH = 2'd2,
      ST_GAP   = 2'd3
   } cfg_state_e;

   localparam logic TGT_BASEBAND = 1'b0;
   localparam logic TGT_SYNTH    = 1'b1;
endpackage

// File: rtl/cfgbus_tick.sv
module cfgbus_tick #(
   parameter int HALF_DIV = 13
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("cfgbus_tick: HALF_DIV must be at least 1");
      end

      if (HALF_DIV == 1) begin : g_every_cycle
         assign tick = run;
      end else begin : g_counter
         localparam int CW = $clog2(HALF_DIV) + 1;
         logic [CW-1:0] cnt_q;
         logic          at_end;

         assign at_end = (cnt_q == CW'(HALF_DIV - 1));
         assign tick   = run && at_end;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!run || at_end) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/cfgbus_shreg.sv
module cfgbus_shreg #(
   parameter int WIDTH = 22
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] load_val,
   input  logic             shift,
   input  logic             in_bit,
   output logic [WIDTH-1:0] q,
   output logic             msb
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("cfgbus_shreg: WIDTH must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (load) begin
         q <= load_val;
      end else if (shift) begin
         q <= {q[WIDTH-2:0], in_bit};
      end
   end

   assign msb = q[WIDTH-1];
endmodule

// File: rtl/cfgbus_master.sv
module cfgbus_master
   import cfgbus_pkg::*;
#(
   parameter int SYS_CLK_HZ  = 250_000_000,
   parameter int SCLK_MAX_HZ = 10_000_000,
   parameter int SCLK_HALF   = 13,
   parameter int ADDR_W      = 7,
   parameter int BB_DATA_W   = 8,
   parameter int SYN_W       = 22,
   parameter int DIN_W       = (SYN_W > BB_DATA_W) ? SYN_W : BB_DATA_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bb_reset_n,
   input  logic                 req_valid,
   input  logic                 req_target,
   input  logic                 req_read,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [DIN_W-1:0]     req_data,
   output logic                 busy,
   output logic                 rd_valid,
   output logic [BB_DATA_W-1:0] rd_data,
   output logic                 sclk,
   output logic                 sdata_o,
   output logic                 sdata_oe,
   input  logic                 sdata_i,
   output logic                 bb_as,
   output logic                 bb_rdwr,
   output logic                 bb_cs_n,
   output logic                 synth_le
);
   localparam int BB_W    = ADDR_W + BB_DATA_W;
   localparam int FRAME_W = (SYN_W > BB_W) ? SYN_W : BB_W;
   localparam int CNT_W   = $clog2(FRAME_W);
   localparam int BB_SH   = FRAME_W - BB_W;
   localparam int SY_SH   = FRAME_W - SYN_W;

   generate
      if (SYS_CLK_HZ / (2 * SCLK_HALF) > SCLK_MAX_HZ) begin : g_sclk_too_fast
         $error("cfgbus_master: SCLK_HALF too small for the serial clock limit");
      end
      if (ADDR_W < 1 || BB_DATA_W < 2 || SYN_W < 2) begin : g_bad_fields
         $error("cfgbus_master: field widths out of range");
      end
      if (DIN_W < SYN_W || DIN_W < BB_DATA_W) begin : g_bad_din
         $error("cfgbus_master: DIN_W narrower than a frame field");
      end
   endgenerate

   cfg_state_e       state_q;
   logic [CNT_W-1:0] bit_q;
   logic             is_syn_q;
   logic             is_rd_q;
   logic             gap_half_q;
   logic             sclk_q;
   logic             oe_q;
   logic             as_q;
   logic             rdwr_q;
   logic             cs_n_q;
   logic             le_q;
   logic             rv_q;

   logic             accept;
   logic             tick;
   logic             rise_now;
   logic             fall_now;
   logic             last_bit;
   logic             tx_shift;
   logic             rx_shift;
   logic             tx_msb;
   logic [FRAME_W-1:0] tx_q;
   logic [FRAME_W-1:0] frame_bb;
   logic [FRAME_W-1:0] frame_sy;
   logic [FRAME_W-1:0] frame_ld;

   assign busy   = (state_q != ST_IDLE);
   assign accept = !busy && req_valid &&
                   ((req_target == TGT_SYNTH) || bb_reset_n);

   assign frame_bb = FRAME_W'({req_addr, req_data[BB_DATA_W-1:0]}) << BB_SH;
   assign frame_sy = FRAME_W'(req_data[SYN_W-1:0]) << SY_SH;
   assign frame_ld = (req_target == TGT_SYNTH) ? frame_sy : frame_bb;

   assign rise_now = (state_q == ST_SHIFT) && tick && !sclk_q;
   assign fall_now = (state_q == ST_SHIFT) && tick && sclk_q;
   assign last_bit = is_syn_q ? (bit_q == CNT_W'(SYN_W - 1))
                              : (bit_q == CNT_W'(BB_W - 1));
   assign tx_shift = fall_now && !last_bit;
   assign rx_shift = rise_now && is_rd_q && (bit_q >= CNT_W'(ADDR_W));

   cfgbus_tick #(
      .HALF_DIV (SCLK_HALF)
   ) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy),
      .tick  (tick)
   );

   cfgbus_shreg #(
      .WIDTH (FRAME_W)
   ) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (frame_ld),
      .shift    (tx_shift),
      .in_bit   (1'b0),
      .q        (tx_q),
      .msb      (tx_msb)
   );

   cfgbus_shreg #(
      .WIDTH (BB_DATA_W)
   ) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val ('0),
      .shift    (rx_shift),
      .in_bit   (sdata_i),
      .q        (rd_data),
      .msb      ()
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         bit_q      <= '0;
         is_syn_q   <= 1'b0;
         is_rd_q    <= 1'b0;
         gap_half_q <= 1'b0;
         sclk_q     <= 1'b0;
         oe_q       <= 1'b0;
         as_q       <= 1'b0;
         rdwr_q     <= 1'b0;
         cs_n_q     <= 1'b1;
         le_q       <= 1'b0;
         rv_q       <= 1'b0;
      end else begin
         rv_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  state_q  <= ST_SHIFT;
                  bit_q    <= '0;
                  sclk_q   <= 1'b0;
                  oe_q     <= 1'b1;
                  is_syn_q <= req_target;
                  is_rd_q  <= (req_target == TGT_BASEBAND) && req_read;
                  if (req_target == TGT_BASEBAND) begin
                     cs_n_q <= 1'b0;
                     as_q   <= 1'b1;
                     rdwr_q <= req_read;
                  end
               end
            end
            ST_SHIFT: begin
               if (rise_now) begin
                  sclk_q <= 1'b1;
               end else if (fall_now) begin
                  sclk_q     <= 1'b0;
                  gap_half_q <= 1'b0;
                  if (last_bit) begin
                     oe_q <= 1'b0;
                     if (is_syn_q) begin
                        state_q <= ST_LATCH;
                        le_q    <= 1'b1;
                     end else begin
                        state_q <= ST_GAP;
                        cs_n_q  <= 1'b1;
                        as_q    <= 1'b0;
                        rdwr_q  <= 1'b0;
                        rv_q    <= is_rd_q;
                     end
                  end else begin
                     bit_q <= bit_q + 1'b1;
                     if (!is_syn_q && bit_q == CNT_W'(ADDR_W - 1)) begin
                        as_q <= 1'b0;
                        if (is_rd_q) begin
                           oe_q <= 1'b0;
                        end
                     end
                  end
               end
            end
            ST_LATCH: begin
               if (tick) begin
                  le_q    <= 1'b0;
                  state_q <= ST_GAP;
               end
            end
            ST_GAP: begin
               if (tick) begin
                  if (gap_half_q) begin
                     state_q <= ST_IDLE;
                  end else begin
                     gap_half_q <= 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign sclk     = sclk_q;
   assign sdata_oe = oe_q;
   assign sdata_o  = tx_msb & oe_q;
   assign bb_as    = as_q;
   assign bb_rdwr  = rdwr_q;
   assign bb_cs_n  = cs_n_q;
   assign synth_le = le_q;
   assign rd_valid = rv_q;
endmodule

// File: rtl/cfgbus_master_chk.sv
module cfgbus_master_chk (
   input logic clk,
   input logic rst_n,
   input logic bb_reset_n,
   input logic busy,
   input logic rd_valid,
   input logic sclk,
   input logic sdata_o,
   input logic sdata_oe,
   input logic bb_as,
   input logic bb_rdwr,
   input logic bb_cs_n,
   input logic synth_le
);
   assert_one_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(!bb_cs_n && synth_le));

   assert_data_setup_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sdata_o) |-> !sclk);

   assert_strobe_setup_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bb_as) |-> !sclk);

   assert_dir_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!bb_cs_n && $past(!bb_cs_n)) |-> $stable(bb_rdwr));

   assert_latch_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      synth_le |-> (!sclk && bb_cs_n && !sdata_oe));

   assert_no_prog_in_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bb_cs_n) |-> $past(bb_reset_n));

   assert_busy_covers_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk || !bb_cs_n || synth_le) |-> busy);

   assert_rdvalid_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $rose(bb_cs_n));
endmodule

bind cfgbus_master cfgbus_master_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bb_reset_n (bb_reset_n),
   .busy       (busy),
   .rd_valid   (rd_valid),
   .sclk       (sclk),
   .sdata_o    (sdata_o),
   .sdata_oe   (sdata_oe),
   .bb_as      (bb_as),
   .bb_rdwr    (bb_rdwr),
   .bb_cs_n    (bb_cs_n),
   .synth_le   (synth_le)
);

// File: tb/cfgbus_master_tb.sv
module cfgbus_master_tb;
   localparam int HALF = 13;
   localparam int AW   = 7;
   localparam int DW   = 8;
   localparam int SW   = 22;
   localparam int BBN  = AW + DW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bb_reset_n = 1'b1;
   logic          req_valid = 1'b0;
   logic          req_target = 1'b0;
   logic          req_read = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [SW-1:0] req_data = '0;
   logic          busy, rd_valid, sclk, sdata_o, sdata_oe;
   logic          bb_as, bb_rdwr, bb_cs_n, synth_le;
   logic [DW-1:0] rd_data;
   logic          sdata_i = 1'b0;

   always #2 clk = ~clk;

   cfgbus_master #(
      .SCLK_HALF (HALF)
   ) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bb_reset_n (bb_reset_n),
      .req_valid  (req_valid),
      .req_target (req_target),
      .req_read   (req_read),
      .req_addr   (req_addr),
      .req_data   (req_data),
      .busy       (busy),
      .rd_valid   (rd_valid),
      .rd_data    (rd_data),
      .sclk       (sclk),
      .sdata_o    (sdata_o),
      .sdata_oe   (sdata_oe),
      .sdata_i    (sdata_i),
      .bb_as      (bb_as),
      .bb_rdwr    (bb_rdwr),
      .bb_cs_n    (bb_cs_n),
      .synth_le   (synth_le)
   );

   int n_cmp = 0;
   int n_bad = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // monitor state, sampled on the falling system clock edge
   longint cyc = 0;
   int     nrise = 0;
   logic [31:0] m_bit, m_as, m_oe, m_cs, m_dir;
   int     per_bad = 0;
   longint last_rise = 0;
   int     le_cnt = 0, le_at = 0, le_len = 0, le_sclk_bad = 0;
   longint le_start = 0, end_cyc = 0;
   int     gap = 0, cs_seen = 0, both_bad = 0, rv_cnt = 0, busy_rises = 0;
   logic [DW-1:0] rv_data = '0;
   logic [DW-1:0] dev_rdval = '0;
   logic   p_sclk = 1'b0, p_le = 1'b0, p_cs = 1'b1, p_busy = 1'b0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (sclk && !p_sclk) begin
            m_bit[nrise] = sdata_o;
            m_as[nrise]  = bb_as;
            m_oe[nrise]  = sdata_oe;
            m_cs[nrise]  = bb_cs_n;
            m_dir[nrise] = bb_rdwr;
            if (nrise > 0 && (cyc - last_rise) != 2 * HALF) per_bad++;
            last_rise = cyc;
            nrise++;
         end
         if (synth_le && !p_le) begin
            le_cnt++;
            le_at = nrise;
            le_start = cyc;
            if (sclk) le_sclk_bad++;
         end
         if (!synth_le && p_le) begin
            le_len = int'(cyc - le_start);
            end_cyc = cyc;
         end
         if (bb_cs_n && !p_cs) end_cyc = cyc;
         if (!bb_cs_n) cs_seen++;
         if (!bb_cs_n && synth_le) both_bad++;
         if (rd_valid) begin
            rv_cnt++;
            rv_data = rd_data;
         end
         if (busy && !p_busy) busy_rises++;
         if (!busy && p_busy) gap = int'(cyc - end_cyc);
         if (!bb_cs_n && bb_rdwr && nrise >= AW && nrise < BBN)
            sdata_i = dev_rdval[DW-1-(nrise-AW)];
         else
            sdata_i = 1'b0;
      end
      p_sclk = sclk;
      p_le   = synth_le;
      p_cs   = bb_cs_n;
      p_busy = busy;
   end

   task automatic clear_mon();
      nrise = 0; per_bad = 0; le_cnt = 0; le_at = 0; le_len = 0;
      le_sclk_bad = 0; gap = 0; cs_seen = 0; both_bad = 0; rv_cnt = 0;
      busy_rises = 0;
   endtask

   function automatic logic exp_bit(input logic tgt, input logic [AW-1:0] a,
                                    input logic [SW-1:0] d, input int idx);
      if (tgt) return d[SW-1-idx];
      if (idx < AW) return a[AW-1-idx];
      return d[DW-1-(idx-AW)];
   endfunction

   task automatic run_txn(input logic tgt, input logic rd, input logic [AW-1:0] a,
                          input logic [SW-1:0] d, input logic [DW-1:0] rv,
                          input bit interfere);
      int exp_n;
      int bit_bad, as_bad, oe_bad, cs_bad, dir_bad;
      logic rdx;
      while (busy) @(negedge clk);
      clear_mon();
      dev_rdval  = rv;
      req_target = tgt;
      req_read   = rd;
      req_addr   = a;
      req_data   = d;
      req_valid  = 1'b1;
      @(negedge clk);
      if (interfere) begin
         req_target = ~tgt;
         req_read   = ~rd;
         req_addr   = ~a;
         req_data   = ~d;
         repeat (60) @(negedge clk);
      end
      req_valid = 1'b0;
      while (busy) @(negedge clk);
      @(negedge clk);
      rdx   = rd & ~tgt;
      exp_n = tgt ? SW : BBN;
      bit_bad = 0; as_bad = 0; oe_bad = 0; cs_bad = 0; dir_bad = 0;
      for (int i = 0; i < exp_n && i < 32; i++) begin
         if (!(rdx && i >= AW) && m_bit[i] !== exp_bit(tgt, a, d, i)) bit_bad++;
         if (!tgt && m_as[i] !== (i < AW)) as_bad++;
         if (m_oe[i] !== !(rdx && i >= AW)) oe_bad++;
         if (m_cs[i] !== tgt) cs_bad++;
         if (!tgt && m_dir[i] !== rd) dir_bad++;
      end
      chk(nrise == exp_n, "R8", "rising edge count (one transaction)", nrise, exp_n);
      chk(busy_rises == 1, "R8", "transactions started", busy_rises, 1);
      chk(bit_bad == 0, "R1", "msb-first bit mismatches", bit_bad, 0);
      chk(per_bad == 0, "R2", "serial period violations", per_bad, 0);
      chk(both_bad == 0, "R8", "both targets active", both_bad, 0);
      chk(gap >= 2 * HALF, "R9", "busy gap after release", gap, 2 * HALF);
      if (tgt) begin
         chk(cs_seen == 0, "R5", "chip select low during synth", cs_seen, 0);
         chk(le_cnt == 1 && le_at == SW, "R7", "latch pulse after bit count",
             le_at, SW);
         chk(le_len == HALF && le_sclk_bad == 0, "R7", "latch pulse length",
             le_len, HALF);
         chk(rv_cnt == 0, "R6", "rd_valid on synth frame", rv_cnt, 0);
      end else begin
         chk(as_bad == 0, "R3", "strobe level mismatches", as_bad, 0);
         chk(cs_bad == 0, "R5", "chip select high inside frame", cs_bad, 0);
         chk(dir_bad == 0, "R4", "direction mismatches", dir_bad, 0);
         chk(oe_bad == 0, "R6", "drive-enable mismatches", oe_bad, 0);
         chk(le_cnt == 0, "R7", "latch pulse on baseband", le_cnt, 0);
         if (rd) begin
            chk(rv_cnt == 1, "R6", "rd_valid pulses", rv_cnt, 1);
            chk(rv_data == rv, "R6", "read data", rv_data, rv);
         end else begin
            chk(rv_cnt == 0, "R6", "rd_valid on write", rv_cnt, 0);
         end
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h1c0f_5eed));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: idle levels after reset
      chk(sclk == 1'b0 && sdata_oe == 1'b0, "R11", "sclk/oe after reset",
          {sclk, sdata_oe}, 0);
      chk(bb_cs_n == 1'b1 && synth_le == 1'b0, "R11", "cs_n/le after reset",
          {bb_cs_n, synth_le}, 2);
      chk(busy == 1'b0 && rd_valid == 1'b0, "R11", "busy/rd_valid after reset",
          {busy, rd_valid}, 0);

      // directed corners
      run_txn(1'b0, 1'b0, 7'h7F, 22'h0000FF, 8'h00, 1'b0);
      run_txn(1'b0, 1'b0, 7'h00, 22'h000000, 8'h00, 1'b0);
      run_txn(1'b0, 1'b0, 7'h40, 22'h000001, 8'h00, 1'b0);
      run_txn(1'b0, 1'b1, 7'h2A, 22'h000000, 8'hA5, 1'b0);
      run_txn(1'b0, 1'b1, 7'h55, 22'h000000, 8'hFF, 1'b0);
      run_txn(1'b0, 1'b1, 7'h01, 22'h000000, 8'h01, 1'b0);
      run_txn(1'b1, 1'b0, 7'h00, 22'h200001, 8'h00, 1'b0);
      run_txn(1'b1, 1'b1, 7'h7F, 22'h3FFFFF, 8'h00, 1'b0);
      // R8: request held while busy must not start a second frame
      run_txn(1'b0, 1'b1, 7'h33, 22'h000000, 8'h3C, 1'b1);
      run_txn(1'b1, 1'b0, 7'h00, 22'h155555, 8'h00, 1'b1);

      // R10: baseband blocked during baseband reset, synth still served
      while (busy) @(negedge clk);
      clear_mon();
      bb_reset_n = 1'b0;
      req_target = 1'b0;
      req_read   = 1'b0;
      req_addr   = 7'h12;
      req_data   = 22'h000034;
      req_valid  = 1'b1;
      repeat (3) @(negedge clk);
      req_valid  = 1'b0;
      repeat (100) @(negedge clk);
      chk(busy_rises == 0 && nrise == 0 && cs_seen == 0, "R10",
          "activity on blocked baseband request", busy_rises + nrise, 0);
      run_txn(1'b1, 1'b0, 7'h00, 22'h2AAAAA, 8'h00, 1'b0);
      bb_reset_n = 1'b1;

      // constrained random traffic
      for (int k = 0; k < 24; k++) begin
         logic          t, r;
         logic [AW-1:0] a;
         logic [SW-1:0] d;
         logic [DW-1:0] v;
         t = 1'($urandom % 2);
         r = 1'($urandom % 2);
         a = AW'($urandom);
         d = t ? SW'($urandom) : SW'($urandom % 256);
         v = DW'($urandom);
         run_txn(t, r, a, d, v, ($urandom % 8) == 0);
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule